// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers interrupt events from five sources and turns them into two request lines, one for urgent work and one for background work. Three external pins are sampled through a synchronizer and each one watches for a rising or a falling transition, chosen by its own polarity bit. A four-bit input group raises one shared event whenever its level differs from a stored snapshot. A one-cycle overflow strobe from a timer forms the fifth source. Each event sets a sticky flag. Only a software clear write removes a flag.

Every flag is gated by a per-source enable and steered by a per-source priority bit. External pin 0 is the exception: it is always urgent. A global enable qualifies both request lines. While the core sleeps, any enabled external-pin flag raises a wake-up line even when the global enable is off. A vector request follows the wake-up only when the global enable is on. Software programs the block through a small write port with four registers, selected by a 2-bit address:

- 0: source enables in bits [4:0] and the global enable in bit 5.
- 1: priority bits [4:0]. 1 means high and 0 means low. Bit 0 has no effect.
- 2: edge polarity for pins [2:0]. 1 means rising and 0 means falling.
- 3: write 1 to clear flag bits [4:0].

Source numbering is pins 0..2, then the input group as 3, then the timer as 4.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset all outputs are low, all enables and priority bits and the global enable are 0, and every edge polarity bit is 1 (rising).
- R2: A pin whose polarity bit is 1 sets its flag on a 0-to-1 transition only. A pin whose polarity bit is 0 sets its flag on a 1-to-0 transition only. The flag is visible at the outputs within 3 clock edges of the pin change.
- R3: A set flag stays set until a write to address 3 with a 1 in that flag's bit. A 0 in that bit leaves the flag unchanged.
- R4: A source with its enable bit at 0 drives no request, but its flag still records the event. Setting the enable later raises the request.
- R5: Pin 0 always drives `irq_hi_o`, whatever priority bit 0 holds. Every other source drives `irq_hi_o` when its priority bit is 1 and `irq_lo_o` when it is 0.
- R6: Any difference between the synchronized input group and its stored snapshot sets flag 3, including a short pulse that returns to the old value. `port_rd_i` reloads the snapshot. A clear write to flag 3 reloads the snapshot and clears the flag.
- R7: A one-cycle `tmr_wrap_i` pulse sets flag 4.
- R8: With the global enable at 0, `irq_hi_o` and `irq_lo_o` are both low whatever flags are set.
- R9: While `sleep_i` is high, `wake_o` is high when an enabled external-pin flag is set, even with the global enable at 0. Flags 3 and 4 never cause wake-up.
- R10: `vector_req_o` is high exactly when `wake_o` is high and the global enable is 1.
- R11: When a timer strobe and a clear of flag 4 happen in the same cycle, the flag ends up set.
- R12: No flag sets at reset release, whatever level the pins or the input group hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 3 | External interrupt pins, asynchronous |
| port_hi_i | input | 4 | Input group watched for changes, asynchronous |
| port_rd_i | input | 1 | Read strobe that reloads the change snapshot |
| tmr_wrap_i | input | 1 | Timer overflow strobe, one cycle |
| sleep_i | input | 1 | Core is sleeping |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select |
| wr_data_i | input | 6 | Register write data |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake-up request to a sleeping core |
| vector_req_o | output | 1 | Branch-to-vector request after wake-up |

## Verification
All four outputs decode the flag, enable and priority state directly, so a wrong internal state shows at the ports in the cycle it arises. A lost or false flag shows up as a missing or spurious request within 3 clock edges of the pin change. A missing snapshot reload shows up as a flag that sets again after a clear. Sweeps over every pin, polarity and transition direction, and over every source and priority value, expose a wrong route or a wrong edge sense.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_PRIO   = 2'd1,
    REG_EDGE   = 2'd2,
    REG_CLEAR  = 2'd3
  } reg_sel_e;

  localparam int unsigned WARM_W = 2;
endpackage

// File: rtl/prio_irq_sync.sv
module prio_irq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/prio_irq_detect.sv
module prio_irq_detect
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT = 3,
  parameter int CHG_W   = 4,
  localparam int NSRC   = NUM_EXT + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_s_i,
  input  logic [CHG_W-1:0]   chg_s_i,
  input  logic [NUM_EXT-1:0] edge_sel_i,
  input  logic               chg_reload_i,
  input  logic               tmr_wrap_i,
  output logic [NSRC-1:0]    evt_o
);
  logic [WARM_W-1:0]  warm_q, warm_d;
  logic               armed;
  logic [NUM_EXT-1:0] prev_q;
  logic [CHG_W-1:0]   snap_q, snap_d;
  logic               snap_ld;

  // Suppress events until the synchronizer holds real pin levels.
  assign armed  = (warm_q == {WARM_W{1'b1}});
  assign warm_d = armed ? warm_q : warm_q + 1'b1;

  assign snap_ld = !armed || chg_reload_i;
  assign snap_d  = snap_ld ? chg_s_i : snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      prev_q <= '0;
      snap_q <= '0;
    end else begin
      warm_q <= warm_d;
      prev_q <= ext_s_i;
      if (snap_ld) snap_q <= snap_d;
    end
  end

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_edge
    logic rise, fall;
    assign rise     = ext_s_i[i] && !prev_q[i];
    assign fall     = !ext_s_i[i] && prev_q[i];
    assign evt_o[i] = armed && (edge_sel_i[i] ? rise : fall);
  end

  assign evt_o[NUM_EXT]   = armed && !chg_reload_i && (chg_s_i != snap_q);
  assign evt_o[NUM_EXT+1] = tmr_wrap_i;
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int NUM_EXT = 3,
  localparam int NSRC   = NUM_EXT + 2,
  localparam int DATA_W = NSRC + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [NSRC-1:0]    evt_i,
  output logic [NSRC-1:0]    en_o,
  output logic [NSRC-1:0]    hi_sel_o,
  output logic [NUM_EXT-1:0] edge_sel_o,
  output logic               gie_o,
  output logic [NSRC-1:0]    flag_o,
  output logic               chg_clr_o
);
  logic [NSRC-1:0]    en_q, flag_q, flag_d, clr_mask;
  logic [NSRC-1:1]    prio_q;
  logic [NUM_EXT-1:0] edge_q;
  logic               gie_q;
  logic               ld_en, ld_prio, ld_edge, ld_clr;

  assign ld_en   = wr_en_i && (wr_addr_i == REG_ENABLE);
  assign ld_prio = wr_en_i && (wr_addr_i == REG_PRIO);
  assign ld_edge = wr_en_i && (wr_addr_i == REG_EDGE);
  assign ld_clr  = wr_en_i && (wr_addr_i == REG_CLEAR);

  assign clr_mask = ld_clr ? wr_data_i[NSRC-1:0] : '0;
  // A set event in the clearing cycle wins.
  assign flag_d   = evt_i | (flag_q & ~clr_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      gie_q  <= 1'b0;
      prio_q <= '0;
      edge_q <= '1;
      flag_q <= '0;
    end else begin
      if (ld_en) begin
        en_q  <= wr_data_i[NSRC-1:0];
        gie_q <= wr_data_i[DATA_W-1];
      end
      if (ld_prio) prio_q <= wr_data_i[NSRC-1:1];
      if (ld_edge) edge_q <= wr_data_i[NUM_EXT-1:0];
      flag_q <= flag_d;
    end
  end

  assign en_o       = en_q;
  assign hi_sel_o   = {prio_q, 1'b1};
  assign edge_sel_o = edge_q;
  assign gie_o      = gie_q;
  assign flag_o     = flag_q;
  assign chg_clr_o  = clr_mask[NUM_EXT];
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NUM_EXT = 3,
  parameter int CHG_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [CHG_W-1:0]   port_hi_i,
  input  logic               port_rd_i,
  input  logic               tmr_wrap_i,
  input  logic               sleep_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [NUM_EXT+2:0] wr_data_i,
  output logic               irq_hi_o,
  output logic               irq_lo_o,
  output logic               wake_o,
  output logic               vector_req_o
);
  localparam int NSRC = NUM_EXT + 2;

  logic [NUM_EXT-1:0] ext_s, edge_sel;
  logic [CHG_W-1:0]   chg_s;
  logic [NSRC-1:0]    evt, enables, hi_sel, flags, live;
  logic               gie, chg_clr;

  prio_irq_sync #(.W(NUM_EXT + CHG_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({port_hi_i, ext_pin_i}),
    .q_o   ({chg_s, ext_s})
  );

  prio_irq_detect #(.NUM_EXT(NUM_EXT), .CHG_W(CHG_W)) u_detect (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_s_i      (ext_s),
    .chg_s_i      (chg_s),
    .edge_sel_i   (edge_sel),
    .chg_reload_i (chg_clr || port_rd_i),
    .tmr_wrap_i   (tmr_wrap_i),
    .evt_o        (evt)
  );

  prio_irq_regs #(.NUM_EXT(NUM_EXT)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .evt_i      (evt),
    .en_o       (enables),
    .hi_sel_o   (hi_sel),
    .edge_sel_o (edge_sel),
    .gie_o      (gie),
    .flag_o     (flags),
    .chg_clr_o  (chg_clr)
  );

  assign live         = flags & enables;
  assign irq_hi_o     = gie && |(live & hi_sel);
  assign irq_lo_o     = gie && |(live & ~hi_sel);
  assign wake_o       = sleep_i && |live[NUM_EXT-1:0];
  assign vector_req_o = wake_o && gie;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic [1:0]      wr_addr_i,
  input logic [NSRC-1:0] clr_bits,
  input logic            tmr_wrap_i,
  input logic            sleep_i,
  input logic [NSRC-1:0] flags,
  input logic            en0,
  input logic            gie,
  input logic            irq_hi_o,
  input logic            irq_lo_o,
  input logic            wake_o,
  input logic            vector_req_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_sticky
    assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[i] && !(wr_en_i && wr_addr_i == 2'd3 && clr_bits[i])) |=> flags[i]);
  end

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_wrap_i |=> flags[NSRC-1]);

  assert_no_req_without_gie_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (!irq_hi_o && !irq_lo_o));

  assert_pin0_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && en0 && gie) |-> irq_hi_o);

  assert_wake_needs_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> sleep_i);

  assert_vector_after_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vector_req_o |-> (wake_o && gie));
endmodule

bind prio_irq_ctrl prio_irq_chk #(.NSRC(NUM_EXT + 2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .clr_bits     (wr_data_i[NUM_EXT+1:0]),
  .tmr_wrap_i   (tmr_wrap_i),
  .sleep_i      (sleep_i),
  .flags        (flags),
  .en0          (enables[0]),
  .gie          (gie),
  .irq_hi_o     (irq_hi_o),
  .irq_lo_o     (irq_lo_o),
  .wake_o       (wake_o),
  .vector_req_o (vector_req_o)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk, rst_n;
  logic [2:0] ext_pin;
  logic [3:0] port_hi;
  logic       port_rd, tmr_wrap, sleep, wr_en;
  logic [1:0] wr_addr;
  logic [5:0] wr_data;
  logic       irq_hi, irq_lo, wake, vreq;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] edge_v;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin), .port_hi_i(port_hi),
    .port_rd_i(port_rd), .tmr_wrap_i(tmr_wrap), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .irq_hi_o(irq_hi), .irq_lo_o(irq_lo), .wake_o(wake), .vector_req_o(vreq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [5:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic fire(input int s);
    if (s < 3) begin
      edge_v[s] = ~ext_pin[s];
      wr(2'd2, {3'b000, edge_v});
      ext_pin[s] = ~ext_pin[s];
      tick(3);
    end else if (s == 3) begin
      port_hi[0] = ~port_hi[0];
      tick(3);
    end else begin
      tmr_wrap = 1'b1;
      tick(1);
      tmr_wrap = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin = 3'b100; port_hi = 4'b1010; port_rd = 0;
    tmr_wrap = 0; sleep = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    edge_v = 3'b111;
    tick(3);
    rst_n = 1'b1;
    tick(6);
    // R1: reset state of outputs
    chk(irq_hi, 0, "R1 hi"); chk(irq_lo, 0, "R1 lo");
    chk(wake, 0, "R1 wake"); chk(vreq, 0, "R1 vec");
    wr(2'd0, 6'h3F); wr(2'd1, 6'h1F);
    tick(2);
    // R12: pin 2 and the input group held nonzero through reset
    chk(irq_hi, 0, "R12 no false event");
    // R1: reset polarity is rising
    ext_pin[1] = 1'b1; tick(3);
    chk(irq_hi, 1, "R1 rising default");
    wr(2'd3, 6'h1F);
    chk(irq_hi, 0, "R3 clear");

    // R2: every pin x polarity x direction
    for (int i = 0; i < 3; i++)
      for (int e = 0; e < 2; e++)
        for (int t = 0; t < 2; t++) begin
          edge_v[i] = e[0];
          wr(2'd2, {3'b000, edge_v});
          ext_pin[i] = ~ext_pin[i];
          tick(3);
          chk(irq_hi, ext_pin[i] == e[0], "R2 edge sense");
          wr(2'd3, 6'h1F);
          chk(irq_hi, 0, "R3 clear after edge");
        end

    // R3: sticky, zero bit in clear leaves it
    fire(0); tick(5);
    ext_pin[0] = ~ext_pin[0]; tick(3);
    wr(2'd3, 6'h1E);
    chk(irq_hi, 1, "R3 sticky");
    wr(2'd3, 6'h01);
    chk(irq_hi, 0, "R3 cleared");

    // R4: disabled source records the event
    wr(2'd0, 6'h3D);
    fire(1);
    chk(irq_hi, 0, "R4 disabled");
    wr(2'd0, 6'h3F);
    chk(irq_hi, 1, "R4 enabled later");
    wr(2'd3, 6'h1F);

    // R5, R6, R7: every source x priority value
    for (int s = 0; s < 5; s++)
      for (int p = 0; p < 2; p++) begin
        wr(2'd1, p ? 6'h1F : 6'h00);
        fire(s);
        chk(irq_hi, (s == 0) || (p == 1), s == 3 ? "R6 route hi" : (s == 4 ? "R7 route hi" : "R5 route hi"));
        chk(irq_lo, !((s == 0) || (p == 1)), "R5 route lo");
        wr(2'd3, 6'h1F);
        tick(3);
        chk(irq_hi | irq_lo, 0, "R3 no residue");
      end

    // R6: each group bit, read strobe, short pulse
    wr(2'd1, 6'h1F);
    for (int k = 0; k < 4; k++) begin
      port_hi[k] = ~port_hi[k]; tick(3);
      chk(irq_hi, 1, "R6 bit change");
      port_rd = 1'b1; tick(1); port_rd = 1'b0;
      wr(2'd3, 6'h08); tick(3);
      chk(irq_hi, 0, "R6 no refire after reload");
    end
    port_hi[2] = ~port_hi[2]; tick(1);
    port_hi[2] = ~port_hi[2]; tick(4);
    chk(irq_hi, 1, "R6 short pulse");
    wr(2'd3, 6'h08); tick(3);
    chk(irq_hi, 0, "R6 clear reloads");

    // R8: global enable gates outputs
    fire(2);
    wr(2'd0, 6'h1F);
    chk(irq_hi, 0, "R8 hi gated"); chk(irq_lo, 0, "R8 lo gated");
    wr(2'd0, 6'h3F);
    chk(irq_hi, 1, "R8 hi back");
    wr(2'd3, 6'h1F);

    // R9, R10: wake and vector
    wr(2'd0, 6'h1F); sleep = 1'b1;
    fire(0);
    chk(wake, 1, "R9 wake without gie");
    chk(vreq, 0, "R10 no vector without gie");
    wr(2'd0, 6'h3F);
    chk(vreq, 1, "R10 vector with gie");
    wr(2'd3, 6'h1F);
    fire(4); fire(3);
    chk(wake, 0, "R9 timer and group do not wake");
    chk(irq_hi, 1, "R7 timer flagged");
    wr(2'd3, 6'h1F); tick(3); sleep = 1'b0;

    // R11: strobe and clear in one cycle
    tmr_wrap = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 6'h10;
    tick(1);
    tmr_wrap = 1'b0; wr_en = 1'b0; wr_data = '0;
    chk(irq_hi, 1, "R11 set wins");
    wr(2'd3, 6'h10);
    chk(irq_hi, 0, "R11 plain clear");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule